// File: doc/BRIEF.md
# Type 1 Configuration Cycle Classifier

This block sits in the address-phase decode path of a PCI-to-PCI bridge. For every address phase it looks at the AD bus, the C/BE# command and which side of the bridge the cycle came from. It compares the addressed bus number against the bridge's primary, secondary and subordinate bus number settings. It then sorts the cycle into one of five classes:

- pass downstream as a Type 1 cycle,
- pass upstream as a Type 1 cycle,
- turn into a special cycle going downstream,
- turn into a special cycle going upstream,
- ignore.

The bridge's transaction logic uses the class code and a direction flag to decide whether to claim the cycle and how to launch it on the far side.

The decode is purely combinational. A parameter selects whether the class and direction leave the block directly or through one register stage. The bus number settings are plain inputs. The block does not handle Type 0 cycles, the conversion from Type 1 to Type 0, or bus timing.

Top module: `t1c_classifier`

## Requirements
- R1: A cycle is classified only when AD[1:0] is 01b. Any other value gives class IGNORE (code 0).
- R2: A cycle seen on the primary side is given class FWD_DN (code 1) when all of the following hold:
  - the command is configuration read (1010b) or configuration write (1011b);
  - the bus number is strictly greater than the secondary bus number and no greater than the subordinate bus number;
  - the cycle does not match R4.
- R3: A cycle seen on the secondary side is given class FWD_UP (code 2) when all of the following hold:
  - the command is configuration write;
  - device AD[15:11] is 11111b and function AD[10:8] is 111b;
  - the bus number is below the secondary bus number or above the subordinate bus number;
  - the cycle does not match R5.
  A configuration read from the secondary side is never forwarded.
- R4: A configuration write seen on the primary side with device 11111b, function 111b, register AD[7:2] = 000000b and bus number equal to the secondary bus number gives class SPC_DN (code 3).
- R5: A configuration write seen on the secondary side with device 11111b, function 111b, register 000000b and bus number equal to the primary bus number gives class SPC_UP (code 4). This takes priority over R3.
- R6: Any command other than configuration read or configuration write gives class IGNORE, as does any cycle that matches none of R2 to R5.
- R7: When the address-phase qualifier is low, the class is IGNORE whatever the other inputs are.
- R8: With REG_OUT = 1, the class and direction appear one clock after the inputs. While reset is asserted they read as 0.
- R9: The direction flag is 1 for FWD_UP and SPC_UP and 0 for every other class.
- R10: The bus number is taken from AD[23:16] only. The other AD bits outside the device, function, register and type fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | High while AD and C/BE# hold a valid address phase |
| from_sec | input | 1 | 0 = cycle seen on the primary side, 1 = on the secondary side |
| ad | input | 32 | Address-phase AD bus |
| cbe | input | 4 | Address-phase bus command |
| pri_bus | input | 8 | Primary bus number setting |
| sec_bus | input | 8 | Secondary bus number setting |
| sub_bus | input | 8 | Subordinate bus number setting |
| cls_o | output | 3 | Class: 0 IGNORE, 1 FWD_DN, 2 FWD_UP, 3 SPC_DN, 4 SPC_UP |
| dir_up_o | output | 1 | 1 when the class moves toward the primary side |

## Verification
The bench builds two copies of the block:

- one with REG_OUT = 1, which exercises the one-clock output timing, the reset value and the clocked assertions;
- one with REG_OUT = 0, which shows that the same decode reaches the ports in the same cycle.

Directed cases hit each bus-range edge: equal to the secondary number, one above it, equal to the subordinate number, and one past it. They also cover the priority of the upstream special cycle over upstream forwarding, a nonzero register number, and a bus number placed in the wrong AD byte. Random cycles drawn around those edges then cross both sides with both commands.

// File: rtl/t1c_pkg.sv
package t1c_pkg;

  typedef enum logic [2:0] {
    T1C_IGNORE = 3'd0,
    T1C_FWD_DN = 3'd1,
    T1C_FWD_UP = 3'd2,
    T1C_SPC_DN = 3'd3,
    T1C_SPC_UP = 3'd4
  } t1c_class_e;

  localparam logic [3:0] T1C_CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] T1C_CMD_CFG_WR = 4'b1011;
  localparam logic [1:0] T1C_KIND_TYPE1 = 2'b01;

  typedef struct packed {
    logic is_type1;
    logic devfn_ones;
    logic reg_zero;
    logic cmd_rd;
    logic cmd_wr;
  } t1c_flags_t;

  typedef struct packed {
    logic above_sec_to_sub;
    logic within_sec_to_sub;
    logic hits_sec;
    logic hits_pri;
  } t1c_range_t;

endpackage

// File: rtl/t1c_field_decode.sv
module t1c_field_decode
  import t1c_pkg::*;
#(
  parameter int AD_W    = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16,
  parameter int CMD_W   = 4
) (
  input  logic [AD_W-1:0]  ad,
  input  logic [CMD_W-1:0] cbe,
  output logic [BUS_W-1:0] bus_num,
  output t1c_flags_t       flags
);
  localparam int BUS_MSB = BUS_LSB + BUS_W - 1;
  localparam int DEV_LSB = 11;
  localparam int FN_LSB  = 8;
  localparam int REG_LSB = 2;

  logic unused_hi;
  assign unused_hi = ^ad[AD_W-1:BUS_MSB+1];

  always_comb begin
    bus_num          = ad[BUS_MSB:BUS_LSB];
    flags.is_type1   = (ad[1:0] == T1C_KIND_TYPE1);
    flags.devfn_ones = (&ad[DEV_LSB+4:DEV_LSB]) && (&ad[FN_LSB+2:FN_LSB]);
    flags.reg_zero   = (ad[REG_LSB+5:REG_LSB] == '0);
    flags.cmd_rd     = (cbe == CMD_W'(T1C_CMD_CFG_RD));
    flags.cmd_wr     = (cbe == CMD_W'(T1C_CMD_CFG_WR));
  end

endmodule

// File: rtl/t1c_range_check.sv
module t1c_range_check
  import t1c_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus_num,
  input  logic [BUS_W-1:0] pri_bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output t1c_range_t       rng
);
  logic gt_sec, ge_sec, le_sub;

  always_comb begin
    gt_sec                = (bus_num >  sec_bus);
    ge_sec                = (bus_num >= sec_bus);
    le_sub                = (bus_num <= sub_bus);
    rng.above_sec_to_sub  = gt_sec && le_sub;
    rng.within_sec_to_sub = ge_sec && le_sub;
    rng.hits_sec          = (bus_num == sec_bus);
    rng.hits_pri          = (bus_num == pri_bus);
  end

endmodule

// File: rtl/t1c_class_select.sv
module t1c_class_select
  import t1c_pkg::*;
(
  input  logic       addr_phase,
  input  logic       from_sec,
  input  t1c_flags_t flags,
  input  t1c_range_t rng,
  output t1c_class_e cls,
  output logic       dir_up
);
  logic spc_base, spc_dn, spc_up, fwd_dn, fwd_up, live;

  always_comb begin
    live     = addr_phase && flags.is_type1;
    spc_base = live && flags.cmd_wr && flags.devfn_ones && flags.reg_zero;
    spc_dn   = spc_base && !from_sec && rng.hits_sec;
    spc_up   = spc_base &&  from_sec && rng.hits_pri;
    fwd_dn   = live && !from_sec && (flags.cmd_rd || flags.cmd_wr)
               && rng.above_sec_to_sub;
    fwd_up   = live &&  from_sec && flags.cmd_wr && flags.devfn_ones
               && !rng.within_sec_to_sub;

    // special cycles outrank plain forwarding
    if (spc_up)      cls = T1C_SPC_UP;
    else if (spc_dn) cls = T1C_SPC_DN;
    else if (fwd_up) cls = T1C_FWD_UP;
    else if (fwd_dn) cls = T1C_FWD_DN;
    else             cls = T1C_IGNORE;

    dir_up = (cls == T1C_SPC_UP) || (cls == T1C_FWD_UP);
  end

endmodule

// File: rtl/t1c_classifier.sv
module t1c_classifier
  import t1c_pkg::*;
#(
  parameter int AD_W    = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16,
  parameter int CMD_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             from_sec,
  input  logic [AD_W-1:0]  ad,
  input  logic [CMD_W-1:0] cbe,
  input  logic [BUS_W-1:0] pri_bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output logic [2:0]       cls_o,
  output logic             dir_up_o
);
  logic [BUS_W-1:0] bus_num;
  t1c_flags_t       flags;
  t1c_range_t       rng;
  t1c_class_e       cls_d;
  logic             dir_d;

  t1c_field_decode #(
    .AD_W(AD_W), .BUS_W(BUS_W), .BUS_LSB(BUS_LSB), .CMD_W(CMD_W)
  ) u_fields (
    .ad(ad), .cbe(cbe), .bus_num(bus_num), .flags(flags)
  );

  t1c_range_check #(.BUS_W(BUS_W)) u_range (
    .bus_num(bus_num), .pri_bus(pri_bus), .sec_bus(sec_bus),
    .sub_bus(sub_bus), .rng(rng)
  );

  t1c_class_select u_select (
    .addr_phase(addr_phase), .from_sec(from_sec), .flags(flags),
    .rng(rng), .cls(cls_d), .dir_up(dir_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [2:0] cls_q;
      logic       dir_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cls_q <= 3'(T1C_IGNORE);
          dir_q <= 1'b0;
        end else begin
          cls_q <= cls_d;
          dir_q <= dir_d;
        end
      end

      assign cls_o    = cls_q;
      assign dir_up_o = dir_q;

      assert_ignore_non_type1_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ad[1:0] != 2'b01) |=> (cls_o == 3'(T1C_IGNORE)));

      assert_no_read_upstream_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (from_sec && cbe == CMD_W'(T1C_CMD_CFG_RD)) |=> !dir_up_o);

      assert_spc_dn_fields_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cls_o == 3'(T1C_SPC_DN)) |-> ($past(ad[7:2]) == 6'd0 && !$past(from_sec)));

      assert_idle_ignored_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !addr_phase |=> (cls_o == 3'(T1C_IGNORE)));

      assert_dir_matches_class_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        dir_up_o == (cls_o == 3'(T1C_FWD_UP) || cls_o == 3'(T1C_SPC_UP)));
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign cls_o      = cls_d;
      assign dir_up_o   = dir_d;
    end
  endgenerate

endmodule

// File: tb/t1c_classifier_test.sv
module t1c_classifier_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_phase = 1'b0;
  logic        from_sec = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic [7:0]  pri_bus = '0, sec_bus = '0, sub_bus = '0;
  logic [2:0]  cls_r, cls_c;
  logic        dir_r, dir_c;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  t1c_classifier #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .from_sec(from_sec),
    .ad(ad), .cbe(cbe), .pri_bus(pri_bus), .sec_bus(sec_bus),
    .sub_bus(sub_bus), .cls_o(cls_r), .dir_up_o(dir_r));

  t1c_classifier #(.REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .from_sec(from_sec),
    .ad(ad), .cbe(cbe), .pri_bus(pri_bus), .sec_bus(sec_bus),
    .sub_bus(sub_bus), .cls_o(cls_c), .dir_up_o(dir_c));

  function automatic logic [3:0] model(logic ph, logic fs, logic [31:0] a,
                                       logic [3:0] c, logic [7:0] p,
                                       logic [7:0] s, logic [7:0] u);
    logic [7:0] b;
    logic m, r0, wr, rd;
    logic [2:0] k;
    b  = a[23:16];
    m  = (a[15:8] == 8'hFF);
    r0 = (a[7:2] == 6'd0);
    wr = (c == 4'b1011);
    rd = (c == 4'b1010);
    k  = 3'd0;
    if (ph && a[1:0] == 2'b01) begin
      if (!fs) begin
        if (wr && m && r0 && b == s)              k = 3'd3;
        else if ((rd || wr) && b > s && b <= u)   k = 3'd1;
      end else begin
        if (wr && m && r0 && b == p)              k = 3'd4;
        else if (wr && m && (b < s || b > u))     k = 3'd2;
      end
    end
    return {(k == 3'd2 || k == 3'd4), k};
  endfunction

  task automatic check(string tag, logic [2:0] got_c, logic got_d,
                       logic [3:0] exp);
    n_cmp++;
    if (got_c !== exp[2:0] || got_d !== exp[3]) begin
      n_bad++;
      $display("FAIL %s: cls=%0d dir=%0d expected cls=%0d dir=%0d",
               tag, got_c, got_d, exp[2:0], exp[3]);
    end
  endtask

  task automatic apply(string tag, logic ph, logic fs, logic [31:0] a,
                       logic [3:0] c);
    logic [3:0] e;
    @(negedge clk);
    addr_phase = ph; from_sec = fs; ad = a; cbe = c;
    e = model(ph, fs, a, c, pri_bus, sec_bus, sub_bus);
    #1 check({tag, " comb"}, cls_c, dir_c, e);
    @(negedge clk);
    check({tag, " reg"}, cls_r, dir_r, e);
  endtask

  function automatic logic [31:0] mk(logic [7:0] b, logic [7:0] devfn,
                                     logic [5:0] rg, logic [1:0] kind);
    return {8'h00, b, devfn, rg, kind};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] bsel;
    logic [31:0] a;
    logic [3:0] c;
    pri_bus = 8'd0; sec_bus = 8'd4; sub_bus = 8'd9;
    addr_phase = 1'b1; from_sec = 1'b0; ad = mk(8'd5, 8'h00, 6'd0, 2'b01);
    cbe = 4'b1011;
    repeat (2) @(negedge clk);
    check("R8 reset", cls_r, dir_r, 4'd0);
    rst_n = 1'b1;

    apply("R1 kind 00", 1, 0, mk(8'd5, 8'h00, 6'd0, 2'b00), 4'b1010);
    apply("R1 kind 11", 1, 1, mk(8'd20, 8'hFF, 6'd0, 2'b11), 4'b1011);
    apply("R2 sec+1 read", 1, 0, mk(8'd5, 8'h12, 6'd3, 2'b01), 4'b1010);
    apply("R2 sub write", 1, 0, mk(8'd9, 8'h00, 6'd1, 2'b01), 4'b1011);
    apply("R2 bus=sec", 1, 0, mk(8'd4, 8'h00, 6'd0, 2'b01), 4'b1010);
    apply("R2 sub+1", 1, 0, mk(8'd10, 8'h00, 6'd0, 2'b01), 4'b1010);
    apply("R3 below sec", 1, 1, mk(8'd2, 8'hFF, 6'd7, 2'b01), 4'b1011);
    apply("R3 above sub", 1, 1, mk(8'd30, 8'hFF, 6'd0, 2'b01), 4'b1011);
    apply("R3 bus=sec", 1, 1, mk(8'd4, 8'hFF, 6'd0, 2'b01), 4'b1011);
    apply("R3 read", 1, 1, mk(8'd30, 8'hFF, 6'd0, 2'b01), 4'b1010);
    apply("R3 devfn miss", 1, 1, mk(8'd30, 8'hFE, 6'd0, 2'b01), 4'b1011);
    apply("R4 spc down", 1, 0, mk(8'd4, 8'hFF, 6'd0, 2'b01), 4'b1011);
    apply("R4 reg nonzero", 1, 0, mk(8'd4, 8'hFF, 6'd1, 2'b01), 4'b1011);
    apply("R4 read", 1, 0, mk(8'd4, 8'hFF, 6'd0, 2'b01), 4'b1010);
    apply("R5 spc up", 1, 1, mk(8'd0, 8'hFF, 6'd0, 2'b01), 4'b1011);
    apply("R5 reg nonzero fwd", 1, 1, mk(8'd0, 8'hFF, 6'd2, 2'b01), 4'b1011);
    apply("R6 other cmd", 1, 0, mk(8'd5, 8'h00, 6'd0, 2'b01), 4'b0110);
    apply("R7 no addr phase", 0, 0, mk(8'd4, 8'hFF, 6'd0, 2'b01), 4'b1011);
    apply("R9 dir down", 1, 0, mk(8'd6, 8'hFF, 6'd0, 2'b01), 4'b1011);
    apply("R10 wrong byte", 1, 0, {8'd5, 8'd0, 8'h00, 6'd0, 2'b01}, 4'b1010);
    apply("R10 high byte", 1, 0, {8'd99, 8'd5, 8'h00, 6'd0, 2'b01}, 4'b1010);

    void'($urandom(32'd20250));
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        pri_bus = 8'($urandom_range(0, 40));
        sec_bus = 8'($urandom_range(0, 200));
        sub_bus = sec_bus + 8'($urandom_range(0, 30));
      end
      case ($urandom_range(0, 5))
        0: bsel = pri_bus;
        1: bsel = sec_bus;
        2: bsel = sec_bus + 8'd1;
        3: bsel = sub_bus;
        4: bsel = sub_bus + 8'd1;
        default: bsel = 8'($urandom);
      endcase
      a = $urandom;
      a[23:16] = bsel;
      if ($urandom_range(0, 1) == 1) a[15:8] = 8'hFF;
      if ($urandom_range(0, 1) == 1) a[7:2] = 6'd0;
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b01;
      case ($urandom_range(0, 2))
        0: c = 4'b1010;
        1: c = 4'b1011;
        default: c = 4'($urandom);
      endcase
      apply("R2-R6 random", ($urandom_range(0, 7) != 0), 1'($urandom), a, c);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule